// File: doc/BRIEF.md
# Partial Timestamp Reconstructor

This block turns a truncated hardware timestamp back into a full 64-bit tick count. A timestamp unit often keeps only the low N bits of the free-running tick counter, which wrap quickly: about 0.135 s for 24 bits and about 34.35 s for 32 bits at 8 ns per tick. The missing upper bits are borrowed from a full counter value that is sampled later. This later sample must fall within one wrap period of the moment the partial value was taken.

Each accepted input pair holds a partial value and a later counter sample. The low N bits of the result are the partial value. The upper bits come from the counter sample, minus one when the low bits of the sample are less than or equal to the partial value, because in that case the counter must have wrapped in between. The result is registered and is presented one cycle after acceptance. N is a parameter, and both 24 and 32 are supported.

Top module: `partialTsRebuild`

## Requirements
- R1: While rstN is low, inReady and outValid are 0 and outTs is all zeros.
- R2: inReady rises at the first rising clock edge at which rstN is high, and then stays high.
- R3: An input is accepted on a rising edge where inValid and inReady are both 1. outValid is 1 for exactly the cycle after each accepted input, and is 0 at all other times.
- R4: Bits [N-1:0] of outTs equal bits [N-1:0] of the accepted partialIn.
- R5: Bits of partialIn at position N and above do not affect outTs.
- R6: If bits [N-1:0] of nowIn are strictly greater than the partial value, bits [63:N] of outTs equal bits [63:N] of nowIn.
- R7: If bits [N-1:0] of nowIn are less than or equal to the partial value, bits [63:N] of outTs equal bits [63:N] of nowIn minus one. The equal case counts as a wrap.
- R8: The subtraction in R7 wraps modulo 2^64. When bits [63:N] of nowIn are zero, bits [63:N] of outTs are all ones.
- R9: outTs keeps its value in every cycle in which no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pair is valid |
| inReady | output | 1 | Block can accept an input |
| partialIn | input | PART_IN_W (32) | Partial timestamp; only bits [PART_W-1:0] are used |
| nowIn | input | FULL_W (64) | Full counter value, sampled after the partial value |
| outValid | output | 1 | One-cycle pulse: outTs holds a new result |
| outTs | output | FULL_W (64) | Reconstructed full timestamp |

## Verification
The bench targets the boundary where the sampled low bits equal the partial value. A design that used a strict less-than test there would return a result one full wrap too late. It also places the sampled low bits one above the partial value, where a design with an off-by-one borrow would wrongly subtract a wrap. A counter sample whose upper bits are zero checks that the borrow wraps to all ones rather than saturating. A partial value with stray upper bits set shows whether a design leaks those bits into the result or into the comparison.

// File: rtl/tsRebuildPkg.sv
package tsRebuildPkg;

  // Strobes that the control sends to the datapath
  typedef struct packed {
    logic captureEn;   // register a new reconstructed value
    logic clearOut;    // force the result register to zero
  } ctrlStrobes_t;

endpackage

// File: rtl/tsRebuildControl.sv
module tsRebuildControl (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  output logic                        outValid,
  output tsRebuildPkg::ctrlStrobes_t  strobes
);

  logic readyQ;
  logic validQ;
  logic accept;

  assign accept = inValid & readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      validQ <= accept;
    end
  end

  always_comb begin
    strobes.captureEn = accept & rstN;
    strobes.clearOut  = ~rstN;
  end

  assign inReady  = readyQ;
  assign outValid = validQ;

  // R2: ready holds once reset has been released for a full cycle
  p_ready_after_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady);

  // R3: each accepted input yields a valid pulse one cycle later
  p_valid_follows_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R3: no valid pulse without an accept in the previous cycle
  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inReady));

endmodule

// File: rtl/tsRebuildDatapath.sv
module tsRebuildDatapath #(
  parameter int FULL_W    = 64,
  parameter int PART_W    = 24,
  parameter int PART_IN_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tsRebuildPkg::ctrlStrobes_t  strobes,
  input  logic [PART_IN_W-1:0]        partialIn,
  input  logic [FULL_W-1:0]           nowIn,
  output logic [FULL_W-1:0]           outTs
);

  localparam int HIGH_W = FULL_W - PART_W;

  logic [PART_W-1:0] partLow;
  logic [PART_W-1:0] nowLow;
  logic [HIGH_W-1:0] nowHigh;
  logic [HIGH_W-1:0] highNext;
  logic              wrapSeen;
  logic [FULL_W-1:0] tsQ;

  // Only the low PART_W bits of the partial input take part
  generate
    if (PART_IN_W > PART_W) begin : g_dropUpper
      logic [PART_IN_W-PART_W-1:0] unusedPartHigh;
      assign unusedPartHigh = partialIn[PART_IN_W-1:PART_W];
      assign partLow        = partialIn[PART_W-1:0];
    end else begin : g_fullWidth
      assign partLow = partialIn[PART_W-1:0];
    end
  endgenerate

  assign nowLow  = nowIn[PART_W-1:0];
  assign nowHigh = nowIn[FULL_W-1:PART_W];

  // Equal low bits count as a completed wrap
  assign wrapSeen = (nowLow <= partLow);

  // Borrow acts only on the upper field; wraps modulo 2^HIGH_W
  assign highNext = nowHigh - {{(HIGH_W-1){1'b0}}, wrapSeen};

  always_ff @(posedge clk) begin
    if (strobes.clearOut) begin
      tsQ <= '0;
    end else if (strobes.captureEn) begin
      tsQ <= {highNext, partLow};
    end
  end

  assign outTs = tsQ;

  // R4: low field of the result is the accepted partial value
  p_low_field_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> outTs[PART_W-1:0] == $past(partialIn[PART_W-1:0]));

  // R6: no borrow when sampled low bits are strictly above the partial value
  p_no_borrow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureEn && (nowIn[PART_W-1:0] > partialIn[PART_W-1:0]))
    |=> outTs[FULL_W-1:PART_W] == $past(nowIn[FULL_W-1:PART_W]));

  // R7: one wrap removed when sampled low bits are at or below the partial value
  p_borrow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureEn && (nowIn[PART_W-1:0] <= partialIn[PART_W-1:0]))
    |=> outTs[FULL_W-1:PART_W] == HIGH_W'($past(nowIn[FULL_W-1:PART_W]) - 1'b1));

  // R9: result holds when nothing is captured
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.captureEn && $past(rstN)) |=> $stable(outTs));

endmodule

// File: rtl/partialTsRebuild.sv
module partialTsRebuild #(
  parameter int FULL_W    = 64,
  parameter int PART_W    = 24,
  parameter int PART_IN_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [PART_IN_W-1:0] partialIn,
  input  logic [FULL_W-1:0]    nowIn,
  output logic                 outValid,
  output logic [FULL_W-1:0]    outTs
);

  tsRebuildPkg::ctrlStrobes_t strobes;

  tsRebuildControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  tsRebuildDatapath #(
    .FULL_W    (FULL_W),
    .PART_W    (PART_W),
    .PART_IN_W (PART_IN_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .partialIn (partialIn),
    .nowIn     (nowIn),
    .outTs     (outTs)
  );

  // R1: outputs quiet while reset is held (checked from the first edge)
  always @(posedge clk) begin
    if (!rstN && $past(!rstN)) begin
      p_reset_quiet_r1: assert (!inReady && !outValid && outTs == '0);
    end
  end

endmodule

// File: tb/partialTsRebuild_test.sv
module partialTsRebuild_test;

  localparam int FULL_W    = 64;
  localparam int PART_W    = 24;
  localparam int PART_IN_W = 32;
  localparam logic [63:0] MASK = (64'd1 << PART_W) - 64'd1;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 inValid;
  logic                 inReady;
  logic [PART_IN_W-1:0] partialIn;
  logic [FULL_W-1:0]    nowIn;
  logic                 outValid;
  logic [FULL_W-1:0]    outTs;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  partialTsRebuild #(.FULL_W(FULL_W), .PART_W(PART_W), .PART_IN_W(PART_IN_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .partialIn(partialIn), .nowIn(nowIn), .outValid(outValid), .outTs(outTs)
  );

  function automatic logic [63:0] refTs(logic [31:0] p, logic [63:0] now);
    logic [63:0] pm;
    logic [63:0] est;
    pm  = {32'd0, p} & MASK;
    est = (now & ~MASK) | pm;
    if ((now & MASK) <= pm) est = est - (64'd1 << PART_W);
    return est;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Apply one pair, then check the registered result on the next negedge
  task automatic applyOne(logic [31:0] p, logic [63:0] now, string req);
    logic [63:0] exp;
    exp = refTs(p, now);
    inValid = 1'b1; partialIn = p; nowIn = now;
    @(negedge clk);
    inValid = 1'b0; partialIn = $urandom(); nowIn = rnd64();
    check(outValid == 1'b1, "R3", {63'd0, outValid}, 64'd1);
    check(outTs == exp, req, outTs, exp);
  endtask

  // An idle cycle: no valid pulse, result held (R3, R9)
  task automatic idleOne();
    logic [63:0] held;
    held = outTs;
    inValid = 1'b0; partialIn = $urandom(); nowIn = rnd64();
    @(negedge clk);
    check(outValid == 1'b0, "R3", {63'd0, outValid}, 64'd0);
    check(outTs == held, "R9", outTs, held);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; inValid = 1'b1; partialIn = 32'h1234_5678; nowIn = 64'hFFFF_0000_1111_2222;
    repeat (3) @(negedge clk);
    // R1: quiet in reset even with inValid high
    check(inReady == 1'b0, "R1", {63'd0, inReady}, 64'd0);
    check(outValid == 1'b0, "R1", {63'd0, outValid}, 64'd0);
    check(outTs == 64'd0, "R1", outTs, 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    // R2: ready after the first edge with reset released
    check(inReady == 1'b1, "R2", {63'd0, inReady}, 64'd1);

    // R7: equal low bits count as a wrap
    applyOne(32'h00AB_CDEF, 64'h0000_0010_00AB_CDEF, "R7");
    // R6: low bits one above the partial value, no borrow
    applyOne(32'h00AB_CDEF, 64'h0000_0010_00AB_CDF0, "R6");
    // R7: low bits one below
    applyOne(32'h0000_0100, 64'h0000_0010_0000_00FF, "R7");
    // R8: upper field zero with a borrow wraps to all ones
    applyOne(32'h0000_0005, 64'h0000_0000_0000_0003, "R8");
    check(outTs[63:PART_W] == {(64-PART_W){1'b1}}, "R8", outTs, refTs(32'h5, 64'h3));
    // R5: stray upper bits of the partial input are ignored
    applyOne(32'hFF00_0010, 64'h0000_0020_0000_0020, "R5");
    check(outTs == 64'h0000_0020_0000_0010, "R5", outTs, 64'h0000_0020_0000_0010);
    // R4: low field equals the partial value, zero partial and zero low bits
    applyOne(32'h0000_0000, 64'hFFFF_FFFF_FF00_0000, "R4");
    applyOne(32'h00FF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    idleOne();
    idleOne();

    // Random pairs: now sampled within one wrap after the partial value
    for (int i = 0; i < 400; i++) begin
      logic [63:0] tsTrue;
      logic [63:0] now;
      logic [31:0] p;
      tsTrue = rnd64();
      now    = tsTrue + {40'd0, 24'($urandom())} + 64'd1;
      p      = tsTrue[31:0] | {($urandom() & 32'hFF), 24'd0};
      applyOne(p, now, "R4");
      check(outTs == tsTrue, "R6", outTs, tsTrue);
      if (($urandom() & 3) == 0) idleOne();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule